// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Data Path

This block carries the data of a clocked synchronous serial port between a CPU register port and a pair of serial pins. One 8-bit shift register does both directions at once. On each shift-enable pulse it sends one bit out of its bit 0 and takes one bit in at its top. Frames of 8, 16, 24 or 32 bits are handled one byte at a time. When a byte is complete, the received byte is copied into one of four receive slots, and the next transmit slot is loaded into the shifter on the same edge. Back-to-back bytes and frames therefore need no idle cycles.

Software fills the transmit slots it needs and then writes the control register. That write selects the frame length and the bit order, and it restarts the frame at slot 0. A ready flag is raised once the last valid byte of a frame has been stored. Reading the last valid receive slot clears the flag. A sticky overrun bit records any frame that completed while the flag was still set. Generating the shift clock, chip selects, interrupts and error detection belong to neighbouring blocks.

Top module: `ssdp_top`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00 and `rx_ready` is 0.
- R2: Register map. Address 0 is control: bits 1:0 are the length code and bit 2 is the order (1 = MSB first). Address 1 is status: bit 0 is ready and bit 1 is overrun. Addresses 4 to 7 are transmit slots 0 to 3, and addresses 8 to 11 are receive slots 0 to 3. `cpu_rdata` shows the addressed value in the cycle after `cpu_rd_en`. A control write restarts the frame at slot 0 and loads transmit slot 0 into the shifter.
- R3: The length code sets the last valid slot: 00 gives slot 0 (8 bits), 01 gives slot 1 (16 bits), 10 gives slot 3 (32 bits), and the prohibited code 11 gives slot 2. A read of a receive slot beyond the last valid slot returns 0x00.
- R4: Within a frame, received bytes fill the slots from slot 0 upward, and the next byte shifts with no gap. `rx_ready` stays 0 until the last valid byte has been stored.
- R5: With order 0, the transmit byte goes out bit 0 first on `ser_out`. The first bit received becomes bit 0 of the stored byte.
- R6: With order 1, the transmit byte goes out bit 7 first. The first bit received becomes bit 7 of the stored byte.
- R7: `rx_ready` and status bit 0 are 1 no later than two clock edges after the shift edge that completes the last valid byte.
- R8: A read of the last valid receive slot clears `rx_ready`. Reads of other slots leave it set.
- R9: If a frame completes while ready is set, the new bytes replace the old ones and status bit 1 is set. That bit stays set until a CPU write with bit 1 = 1 to the status register. A write of 0 leaves it set.
- R10: CPU writes to the receive slots, and to status bit 0, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_rd_en | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| shift_en | input | 1 | One pulse per serial bit time |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out (shifter bit 0) |
| rx_ready | output | 1 | Receive data ready flag |

## Verification
A wrong bit count or slot index shows up within one byte time. Either the bits on `ser_out` no longer match the transmit slot, or received bytes land in the wrong slot, and the next register read exposes it. Order or reversal faults appear as mirrored bytes, both on the serial output and in loopback read-back. Errors in the flag state appear as `rx_ready` rising mid-frame, failing to rise within two edges of the last shift, or not clearing on the final read. A lost or spurious overrun is visible in the next status read.

// File: rtl/ssdp_pkg.sv
package ssdp_pkg;

  typedef enum logic [1:0] {
    LEN_8   = 2'b00,
    LEN_16  = 2'b01,
    LEN_32  = 2'b10,
    LEN_BAD = 2'b11
  } len_e;

  // Index of the final byte slot in a frame for each length code.
  function automatic logic [1:0] final_slot(input len_e len);
    case (len)
      LEN_8:   final_slot = 2'd0;
      LEN_16:  final_slot = 2'd1;
      LEN_32:  final_slot = 2'd3;
      default: final_slot = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/ssdp_shifter.sv
module ssdp_shifter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic              msb_first,
  input  logic [SLOT_W-1:0] last_slot,
  output logic [SLOT_W-1:0] load_slot,
  input  logic [DATA_W-1:0] load_data,
  output logic              ser_out,
  output logic              done_valid,
  output logic [SLOT_W-1:0] done_slot,
  output logic [DATA_W-1:0] done_data,
  output logic              done_last
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sreg;
  logic [DATA_W-1:0] sreg_nxt;
  logic [DATA_W-1:0] load_ord;
  logic [DATA_W-1:0] rx_ord;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot;
  logic              byte_end;
  logic              at_last;

  assign sreg_nxt = {ser_in, sreg[DATA_W-1:1]};

  // Bit order is applied when a byte enters or leaves the shifter.
  for (genvar g = 0; g < DATA_W; g++) begin : g_order
    assign load_ord[g] = msb_first ? load_data[DATA_W-1-g] : load_data[g];
    assign rx_ord[g]   = msb_first ? sreg_nxt[DATA_W-1-g]  : sreg_nxt[g];
  end

  assign byte_end  = shift_en && (bit_cnt == CNT_TOP);
  assign at_last   = (slot == last_slot);
  assign load_slot = (restart || at_last) ? '0 : slot + 1'b1;
  assign ser_out   = sreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg       <= '0;
      bit_cnt    <= '0;
      slot       <= '0;
      done_valid <= 1'b0;
      done_slot  <= '0;
      done_data  <= '0;
      done_last  <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      done_last  <= 1'b0;
      if (restart) begin
        sreg    <= load_ord;
        bit_cnt <= '0;
        slot    <= '0;
      end else if (byte_end) begin
        sreg       <= load_ord;
        bit_cnt    <= '0;
        slot       <= load_slot;
        done_valid <= 1'b1;
        done_slot  <= slot;
        done_data  <= rx_ord;
        done_last  <= at_last;
      end else if (shift_en) begin
        sreg    <= sreg_nxt;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_SEROUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !restart) |=> $stable(ser_out)); // R5

  AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R4

  AST_RESTART_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    restart |=> !done_valid); // R2

endmodule

// File: rtl/ssdp_regs.sv
module ssdp_regs
  import ssdp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_wr_en,
  input  logic                       cpu_rd_en,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic                       start,
  output logic                       msb_first,
  output logic [$clog2(SLOTS)-1:0]   last_slot,
  input  logic [$clog2(SLOTS)-1:0]   load_slot,
  output logic [DATA_W-1:0]          load_data,
  input  logic                       done_valid,
  input  logic [$clog2(SLOTS)-1:0]   done_slot,
  input  logic [DATA_W-1:0]          done_data,
  input  logic                       done_last,
  output logic                       rx_ready
);

  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned PAGE_W = ADDR_W - SLOT_W;
  localparam logic [PAGE_W-1:0] PG_CSR = PAGE_W'(0);
  localparam logic [PAGE_W-1:0] PG_TX  = PAGE_W'(1);
  localparam logic [PAGE_W-1:0] PG_RX  = PAGE_W'(2);
  localparam logic [SLOT_W-1:0] SL_CTRL = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SL_STAT = SLOT_W'(1);

  logic [DATA_W-1:0] tx_mem [SLOTS];
  logic [DATA_W-1:0] rx_mem [SLOTS];
  len_e              len_q;
  logic              ovr_q;
  logic [SLOT_W-1:0] a_slot;
  logic [PAGE_W-1:0] a_page;
  logic              hit_ctrl, hit_stat, hit_tx, hit_rx;
  logic              rd_last, frame_in;
  logic [DATA_W-1:0] rd_mux;

  assign a_slot   = cpu_addr[SLOT_W-1:0];
  assign a_page   = cpu_addr[ADDR_W-1:SLOT_W];
  assign hit_ctrl = (a_page == PG_CSR) && (a_slot == SL_CTRL);
  assign hit_stat = (a_page == PG_CSR) && (a_slot == SL_STAT);
  assign hit_tx   = (a_page == PG_TX);
  assign hit_rx   = (a_page == PG_RX);

  assign last_slot = SLOT_W'(final_slot(len_q));
  assign load_data = tx_mem[load_slot];
  assign rd_last   = cpu_rd_en && hit_rx && (a_slot == last_slot);
  assign frame_in  = done_valid && done_last;

  // Transmit slots: CPU write port, asynchronous read toward the shifter.
  always_ff @(posedge clk) begin
    if (cpu_wr_en && hit_tx) tx_mem[a_slot] <= cpu_wdata;
  end

  // Receive slots: single write port fed only by the shifter.
  always_ff @(posedge clk) begin
    if (done_valid) rx_mem[done_slot] <= done_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= LEN_8;
      msb_first <= 1'b0;
      start     <= 1'b0;
    end else begin
      start <= cpu_wr_en && hit_ctrl;
      if (cpu_wr_en && hit_ctrl) begin
        len_q     <= len_e'(cpu_wdata[1:0]);
        msb_first <= cpu_wdata[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (frame_in)     rx_ready <= 1'b1;
      else if (rd_last) rx_ready <= 1'b0;
      if (frame_in && rx_ready && !rd_last)     ovr_q <= 1'b1;
      else if (cpu_wr_en && hit_stat && cpu_wdata[1]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)                           rd_mux = DATA_W'({msb_first, len_q});
    else if (hit_stat)                      rd_mux = DATA_W'({ovr_q, rx_ready});
    else if (hit_tx)                        rd_mux = tx_mem[a_slot];
    else if (hit_rx && a_slot <= last_slot) rd_mux = rx_mem[a_slot];
  end

  always_ff @(posedge clk) begin
    if (rst)            cpu_rdata <= '0;
    else if (cpu_rd_en) cpu_rdata <= rd_mux;
  end

  AST_READY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    frame_in |=> rx_ready); // R7

  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && !frame_in) |=> !rx_ready); // R4

  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_last && !frame_in) |=> !rx_ready); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !(cpu_wr_en && hit_stat && cpu_wdata[1])) |=> ovr_q); // R9

  AST_RX_CPU_PROOF: assert property (@(posedge clk) disable iff (rst)
    !done_valid |=> ($stable(rx_mem[0]) && $stable(rx_mem[SLOTS-1]))); // R10

endmodule

// File: rtl/ssdp_top.sv
module ssdp_top #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              rx_ready
);

  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic              start;
  logic              msb_first;
  logic [SLOT_W-1:0] last_slot;
  logic [SLOT_W-1:0] load_slot;
  logic [DATA_W-1:0] load_data;
  logic              done_valid;
  logic [SLOT_W-1:0] done_slot;
  logic [DATA_W-1:0] done_data;
  logic              done_last;

  ssdp_regs #(.DATA_W(DATA_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cpu_wr_en  (cpu_wr_en),
    .cpu_rd_en  (cpu_rd_en),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .start      (start),
    .msb_first  (msb_first),
    .last_slot  (last_slot),
    .load_slot  (load_slot),
    .load_data  (load_data),
    .done_valid (done_valid),
    .done_slot  (done_slot),
    .done_data  (done_data),
    .done_last  (done_last),
    .rx_ready   (rx_ready)
  );

  ssdp_shifter #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .restart    (start),
    .shift_en   (shift_en),
    .ser_in     (ser_in),
    .msb_first  (msb_first),
    .last_slot  (last_slot),
    .load_slot  (load_slot),
    .load_data  (load_data),
    .ser_out    (ser_out),
    .done_valid (done_valid),
    .done_slot  (done_slot),
    .done_data  (done_data),
    .done_last  (done_last)
  );

endmodule

// File: tb/ssdp_top_tb.sv
module ssdp_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr_en = 1'b0;
  logic       cpu_rd_en = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       shift_en = 1'b0;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic       rx_ready;

  int tests = 0;
  int fails = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_q = 1'b0;

  logic [7:0] tx_b [4];
  logic [7:0] rx_b [4];

  always #4 clk = ~clk;

  ssdp_top u_dut (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out), .rx_ready(rx_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected item per issued read.
  always @(posedge clk) rd_q <= cpu_rd_en;
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(cpu_rdata == e, t, 32'(cpu_rdata), 32'(e));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    cpu_rd_en = 1'b1; cpu_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    cpu_rd_en = 1'b0;
  endtask

  task automatic start(input logic [1:0] len, input bit msb);
    wr(4'd0, {5'b0, msb, len});
    @(negedge clk);
  endtask

  task automatic run_frame(input int n, input bit msb, input bit mid_chk);
    logic [7:0] obs;
    for (int k = 0; k < n; k++) begin
      obs = '0;
      for (int i = 0; i < 8; i++) begin
        int bi;
        bi = msb ? 7 - i : i;
        obs[bi] = ser_out;
        ser_in = rx_b[k][bi];
        shift_en = 1'b1;
        if (mid_chk && k == n - 1 && i == 4)
          check(rx_ready == 1'b0, "R4 ready low before last byte", 32'(rx_ready), 0);
        @(negedge clk);
      end
      check(obs == tx_b[k], msb ? "R6 MSB-first serial out" : "R5 LSB-first serial out",
            32'(obs), 32'(tx_b[k]));
    end
    shift_en = 1'b0;
    ser_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(rx_ready == 1'b0, "R1 rx_ready after reset", 32'(rx_ready), 0);
    rd(4'd0, 8'h00, "R1 control after reset");
    rd(4'd1, 8'h00, "R1 status after reset");

    // 8-bit LSB-first loopback
    wr(4'd4, 8'hA5); tx_b[0] = 8'hA5; rx_b[0] = 8'hA5;
    rd(4'd4, 8'hA5, "R2 transmit slot readback");
    start(2'b00, 1'b0);
    rd(4'd0, 8'h00, "R2 control readback");
    run_frame(1, 1'b0, 1'b0);
    check(rx_ready == 1'b1, "R7 ready after 8-bit frame", 32'(rx_ready), 1);
    rd(4'd1, 8'h01, "R7 status ready bit");
    rd(4'd9, 8'h00, "R3 slot1 invalid at length 00");
    check(rx_ready == 1'b1, "R8 invalid-slot read keeps ready", 32'(rx_ready), 1);
    rd(4'd8, 8'hA5, "R5 LSB-first receive slot0");
    check(rx_ready == 1'b0, "R8 last-slot read clears ready", 32'(rx_ready), 0);

    // 8-bit MSB-first, external receive pattern
    wr(4'd4, 8'h3C); tx_b[0] = 8'h3C; rx_b[0] = 8'h96;
    start(2'b00, 1'b1);
    rd(4'd0, 8'h04, "R2 control order bit");
    run_frame(1, 1'b1, 1'b0);
    rd(4'd8, 8'h96, "R6 MSB-first receive");
    check(rx_ready == 1'b0, "R8 clear after MSB frame", 32'(rx_ready), 0);

    // 16-bit LSB-first
    wr(4'd4, 8'h12); wr(4'd5, 8'h34);
    tx_b[0] = 8'h12; tx_b[1] = 8'h34; rx_b[0] = 8'h5A; rx_b[1] = 8'hC3;
    start(2'b01, 1'b0);
    run_frame(2, 1'b0, 1'b1);
    check(rx_ready == 1'b1, "R7 ready after 16-bit frame", 32'(rx_ready), 1);
    rd(4'd10, 8'h00, "R3 slot2 invalid at length 01");
    rd(4'd8, 8'h5A, "R4 slot0 of 16-bit frame");
    check(rx_ready == 1'b1, "R8 non-last read keeps ready", 32'(rx_ready), 1);
    rd(4'd9, 8'hC3, "R4 slot1 of 16-bit frame");
    check(rx_ready == 1'b0, "R8 slot1 read clears ready", 32'(rx_ready), 0);

    // 32-bit MSB-first loopback
    tx_b[0] = 8'h11; tx_b[1] = 8'h22; tx_b[2] = 8'h84; tx_b[3] = 8'hF0;
    for (int s = 0; s < 4; s++) begin
      wr(4'(4 + s), tx_b[s]);
      rx_b[s] = tx_b[s];
    end
    start(2'b10, 1'b1);
    run_frame(4, 1'b1, 1'b1);
    check(rx_ready == 1'b1, "R7 ready after 32-bit frame", 32'(rx_ready), 1);
    rd(4'd8,  8'h11, "R4 slot0 of 32-bit frame");
    rd(4'd9,  8'h22, "R4 slot1 of 32-bit frame");
    rd(4'd10, 8'h84, "R4 slot2 of 32-bit frame");
    check(rx_ready == 1'b1, "R8 slot2 read keeps ready at length 10", 32'(rx_ready), 1);
    rd(4'd11, 8'hF0, "R3 slot3 valid at length 10");
    check(rx_ready == 1'b0, "R8 slot3 read clears ready", 32'(rx_ready), 0);

    // prohibited code 11: three slots
    tx_b[0] = 8'h01; tx_b[1] = 8'h02; tx_b[2] = 8'h03;
    for (int s = 0; s < 3; s++) wr(4'(4 + s), tx_b[s]);
    rx_b[0] = 8'h9A; rx_b[1] = 8'hBC; rx_b[2] = 8'hDE;
    start(2'b11, 1'b0);
    run_frame(3, 1'b0, 1'b1);
    rd(4'd11, 8'h00, "R3 slot3 invalid at code 11");
    check(rx_ready == 1'b1, "R7 ready after code-11 frame", 32'(rx_ready), 1);
    rd(4'd8,  8'h9A, "R3 slot0 at code 11");
    rd(4'd9,  8'hBC, "R3 slot1 at code 11");
    rd(4'd10, 8'hDE, "R3 slot2 at code 11");
    check(rx_ready == 1'b0, "R8 slot2 read clears ready at code 11", 32'(rx_ready), 0);

    // overrun: two 8-bit frames without reading
    wr(4'd4, 8'h5A); tx_b[0] = 8'h5A;
    start(2'b00, 1'b0);
    rx_b[0] = 8'h11;
    run_frame(1, 1'b0, 1'b0);
    rx_b[0] = 8'h22;
    run_frame(1, 1'b0, 1'b0);
    rd(4'd1, 8'h03, "R9 overrun and ready set");
    rd(4'd8, 8'h22, "R9 newer frame overwrites");
    rd(4'd1, 8'h02, "R9 overrun sticky after read");
    wr(4'd1, 8'h00);
    rd(4'd1, 8'h02, "R9 write 0 keeps overrun");
    wr(4'd1, 8'h02);
    rd(4'd1, 8'h00, "R9 write 1 clears overrun");

    // CPU writes to receive slots and ready bit
    wr(4'd8, 8'hFF);
    rd(4'd8, 8'h22, "R10 receive slot write ignored");
    wr(4'd1, 8'h01);
    rd(4'd1, 8'h00, "R10 status ready not writable");
    check(rx_ready == 1'b0, "R10 rx_ready unchanged by write", 32'(rx_ready), 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads returned", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule